// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a 16-bit segment selector and a 32-bit offset into a 32-bit linear address. When a segment register is loaded, the block reads the selector's 8-byte descriptor from the global or the local table. It does this through a simple 32-bit read port, as two word reads. It then unpacks the descriptor into a shadow register. Each later access is checked against the shadowed segment's limit, its type and its privilege. The result is a linear address, an ok flag, and a fault flag with a cause code.

In real mode a load does not touch memory. It builds a byte-granular data segment directly from the selector. The global table base and limit, the cached local table base, the current privilege level (CPL) and the real-mode flag are plain inputs that the surrounding core keeps up to date.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `busy`, `mem_rd`, `fault` and `acc_done` are low. A protected load reads two words and asserts `busy` from the cycle after `ld_req` until the shadow is valid. The first word is at table base (`ldt_base` when selector bit 2 is 1, else `gdt_base`) plus the selector with bits 2:0 cleared. The second word is at that address plus 4. `mem_addr` holds steady while a read waits for `mem_ack`.
- R2: If selector bit 2 is 0 and the selector with bits 2:0 set is greater than `gdt_limit`, `fault` is raised with cause 5 in the next cycle. No read is issued in that case.
- R3: The descriptor is the second word above the first. It unpacks as follows:
  - base = {bits 63:56, bits 39:16}
  - limit = {bits 51:48, bits 15:0}
  - G = bit 55
  - access byte = bits 47:40: P is bit 7, DPL is bits 6:5, S is bit 4, and type is bits 3:1 (1,C,R for code and 0,ED,W for data)
- R4: A fetched descriptor with P=0 raises `fault` with cause 4 in the cycle after the second `mem_ack`. The segment is then left unusable.
- R5: The effective limit is the 20-bit limit when G=0, and (limit×4096)+4095 when G=1. An offset above the effective limit gives cause 1.
- R6: Access kind is encoded as 0 = read, 1 = write, 2 = fetch; 3 counts as a read. The following give cause 2:
  - any access to a segment with S=0
  - a write to a code segment
  - a fetch from a data segment
- R7: A read or write to a data segment whose DPL is less than max(CPL, RPL) gives cause 3. RPL is the selector's bits 1:0 at load time.
- R8: With `real_mode` high, a load sets base = selector×16 and limit 0xFFFF with no memory read, and the segment is usable on the next cycle. Real-mode accesses check only the limit.
- R9: `acc_req` gives `acc_done`, `acc_ok` and `lin_addr` = base + offset in the next cycle. A failing access also raises `fault` with its cause. The cause is 0 whenever `fault` is low.
- R10: The access cause is chosen in this priority order:
  - 6 (no valid segment)
  - 2 (type)
  - 3 (privilege)
  - 1 (limit)
- R11: `ld_req` while `busy` is ignored. The shadow is invalid from a protected load's start until it completes, so an access in that window gives cause 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| real_mode | input | 1 | Real-mode addressing selected |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | 32 | Global table linear base |
| gdt_limit | input | 16 | Global table byte limit |
| ldt_base | input | 32 | Cached local table base |
| ld_req | input | 1 | Load the selector into the shadow |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| mem_rd | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| acc_req | input | 1 | Check and translate an access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_off | input | 32 | Access offset |
| acc_done | output | 1 | Access result valid |
| acc_ok | output | 1 | Access permitted |
| lin_addr | output | 32 | Base plus offset |
| fault | output | 1 | Load or access fault |
| fault_cause | output | 3 | 0 none, 1 limit, 2 type, 3 privilege, 4 absent, 5 table, 6 no segment |

## Verification
- **Access results:** These are due exactly one clock after `acc_req`.
- **Table-limit fault:** This is also due one clock after `ld_req`.
- **Not-present fault and shadow validity:** Both are due one clock after the second `mem_ack`. Because `mem_ack` can be held back by a chosen number of wait cycles, `busy` and the read address have to follow that handshake rather than a fixed delay.
- **How the checks keep to this timing:** A behavioural model in the bench steps on the same edge as the design and predicts every output. Outputs are compared on every falling edge, so a result that arrives one cycle early or late is reported as a miscompare.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int ADDR_W  = 32;
    localparam int SEL_W   = 16;
    localparam int LIM_W   = 20;
    localparam int DESC_W  = 64;

    typedef enum logic [2:0] {
        CZ_NONE   = 3'd0,
        CZ_LIMIT  = 3'd1,
        CZ_TYPE   = 3'd2,
        CZ_PRIV   = 3'd3,
        CZ_ABSENT = 3'd4,
        CZ_TABLE  = 3'd5,
        CZ_NOSEG  = 3'd6
    } cause_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'd0,
        AK_WRITE = 2'd1,
        AK_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_LO   = 2'd1,
        LS_HI   = 2'd2
    } load_st_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
        logic              big;
        logic              present;
        logic [1:0]        dpl;
        logic              usr;
        logic [2:0]        kind;
        logic [1:0]        rpl;
    } shadow_t;

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    input  logic [1:0]        rpl,
    output shadow_t           sh
);
    logic [7:0] acc_byte;

    always_comb begin
        acc_byte   = raw[47:40];
        sh.base    = {raw[63:56], raw[39:16]};
        sh.limit   = {raw[51:48], raw[15:0]};
        sh.gran    = raw[55];
        sh.big     = raw[54];
        sh.present = acc_byte[7];
        sh.valid   = acc_byte[7];
        sh.dpl     = acc_byte[6:5];
        sh.usr     = acc_byte[4];
        sh.kind    = acc_byte[3:1];
        sh.rpl     = rpl;
    end
endmodule

// File: rtl/seg_loader.sv
module seg_loader
    import seg_pkg::*;
#(
    parameter int               REAL_SHIFT = 4,
    parameter logic [LIM_W-1:0] REAL_LIMIT = 20'h0FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic              real_mode,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [15:0]       gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output shadow_t           shadow,
    output logic              flt,
    output cause_e            flt_cause
);
    localparam int IDX_W = SEL_W - 3;

    typedef struct packed {
        load_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       lo;
        logic [1:0]        rpl;
        shadow_t           sh;
        logic              flt;
        cause_e            cause;
    } ld_state_t;

    ld_state_t q, d;
    shadow_t   dec;
    logic      past_end;

    seg_desc_unpack u_unpack (
        .raw (({mem_rdata, q.lo})),
        .rpl (q.rpl),
        .sh  (dec)
    );

    always_comb begin
        past_end = {1'b0, ld_sel[SEL_W-1:3], 3'b111} > {1'b0, gdt_limit};
        d        = q;
        d.flt    = 1'b0;
        d.cause  = CZ_NONE;
        unique case (q.st)
            LS_IDLE: begin
                if (ld_req) begin
                    d.rpl = ld_sel[1:0];
                    if (real_mode) begin
                        d.sh         = '0;
                        d.sh.valid   = 1'b1;
                        d.sh.base    = ADDR_W'(ld_sel) << REAL_SHIFT;
                        d.sh.limit   = REAL_LIMIT;
                        d.sh.present = 1'b1;
                        d.sh.usr     = 1'b1;
                        d.sh.kind    = 3'b001;
                        d.sh.rpl     = ld_sel[1:0];
                    end else begin
                        d.sh.valid = 1'b0;
                        if (!ld_sel[2] && past_end) begin
                            d.flt   = 1'b1;
                            d.cause = CZ_TABLE;
                        end else begin
                            d.st   = LS_LO;
                            d.addr = (ld_sel[2] ? ldt_base : gdt_base)
                                   + {{(ADDR_W-IDX_W-3){1'b0}}, ld_sel[SEL_W-1:3], 3'b000};
                        end
                    end
                end
            end
            LS_LO: begin
                if (mem_ack) begin
                    d.lo = mem_rdata;
                    d.st = LS_HI;
                end
            end
            LS_HI: begin
                if (mem_ack) begin
                    d.st = LS_IDLE;
                    d.sh = dec;
                    if (!dec.present) begin
                        d.sh.valid = 1'b0;
                        d.flt      = 1'b1;
                        d.cause    = CZ_ABSENT;
                    end
                end
            end
            default: d.st = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= LS_IDLE;
            q.cause <= CZ_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != LS_IDLE);
    assign mem_rd    = (q.st != LS_IDLE);
    assign mem_addr  = (q.st == LS_HI) ? q.addr + ADDR_W'(4) : q.addr;
    assign shadow    = q.sh;
    assign flt       = q.flt;
    assign flt_cause = q.cause;
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
    import seg_pkg::*;
#(
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_off,
    input  logic              real_mode,
    input  logic [1:0]        cpl,
    input  shadow_t           sh,
    output logic              acc_done,
    output logic              acc_ok,
    output cause_e            acc_cause,
    output logic [ADDR_W-1:0] lin_addr
);
    localparam logic [ADDR_W-1:0] UNIT_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

    typedef struct packed {
        logic              done;
        logic              ok;
        cause_e            cause;
        logic [ADDR_W-1:0] lin;
    } acc_state_t;

    acc_state_t        q, d;
    logic [ADDR_W-1:0] eff_lim;
    logic [1:0]        need_lvl;
    cause_e            why;

    always_comb begin
        eff_lim  = sh.gran ? ((ADDR_W'(sh.limit) << PAGE_SHIFT) | UNIT_MASK)
                           : ADDR_W'(sh.limit);
        need_lvl = (cpl > sh.rpl) ? cpl : sh.rpl;
        why      = CZ_NONE;
        if (!sh.valid) begin
            why = CZ_NOSEG;
        end else if (!real_mode && !sh.usr) begin
            why = CZ_TYPE;
        end else if (!real_mode && sh.kind[2] && acc_kind == AK_WRITE) begin
            why = CZ_TYPE;
        end else if (!real_mode && !sh.kind[2] && acc_kind == AK_FETCH) begin
            why = CZ_TYPE;
        end else if (!real_mode && !sh.kind[2] && sh.dpl < need_lvl) begin
            why = CZ_PRIV;
        end else if (acc_off > eff_lim) begin
            why = CZ_LIMIT;
        end
        d.done  = acc_req;
        d.ok    = acc_req && (why == CZ_NONE);
        d.cause = acc_req ? why : CZ_NONE;
        d.lin   = sh.base + acc_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cause <= CZ_NONE;
        end else begin
            q <= d;
        end
    end

    assign acc_done  = q.done;
    assign acc_ok    = q.ok;
    assign acc_cause = q.cause;
    assign lin_addr  = q.lin;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int               PAGE_SHIFT = 12,
    parameter int               REAL_SHIFT = 4,
    parameter logic [LIM_W-1:0] REAL_LIMIT = 20'h0FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              real_mode,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [15:0]       gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic              ld_req,
    input  logic [SEL_W-1:0]  ld_sel,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              acc_req,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_off,
    output logic              acc_done,
    output logic              acc_ok,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              fault,
    output logic [2:0]        fault_cause
);
    shadow_t shadow;
    logic    ld_flt;
    cause_e  ld_cause;
    cause_e  ac_cause;

    seg_loader #(
        .REAL_SHIFT (REAL_SHIFT),
        .REAL_LIMIT (REAL_LIMIT)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_req    (ld_req),
        .ld_sel    (ld_sel),
        .real_mode (real_mode),
        .gdt_base  (gdt_base),
        .gdt_limit (gdt_limit),
        .ldt_base  (ldt_base),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .shadow    (shadow),
        .flt       (ld_flt),
        .flt_cause (ld_cause)
    );

    seg_access_chk #(
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_kind  (acc_kind),
        .acc_off   (acc_off),
        .real_mode (real_mode),
        .cpl       (cpl),
        .sh        (shadow),
        .acc_done  (acc_done),
        .acc_ok    (acc_ok),
        .acc_cause (ac_cause),
        .lin_addr  (lin_addr)
    );

    always_comb begin
        fault       = ld_flt || (acc_done && !acc_ok);
        fault_cause = ld_flt ? ld_cause : ac_cause;
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        real_mode,
    input logic [15:0] gdt_limit,
    input logic        ld_req,
    input logic [15:0] ld_sel,
    input logic        busy,
    input logic        mem_rd,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        acc_req,
    input logic        acc_done,
    input logic        fault,
    input logic [2:0]  fault_cause
);
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr))); // R1

    AST_TABLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !busy && !real_mode && !ld_sel[2]
         && ({1'b0, ld_sel[15:3], 3'b111} > {1'b0, gdt_limit}))
        |=> (fault && fault_cause == 3'd5 && !mem_rd)); // R2

    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 3'd0)); // R4

    AST_REAL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !busy && real_mode) |=> (!mem_rd && !busy)); // R8

    AST_ACC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> acc_done); // R9

    AST_NO_FAULT_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_cause == 3'd0)); // R9

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> busy); // R11
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .real_mode   (real_mode),
    .gdt_limit   (gdt_limit),
    .ld_req      (ld_req),
    .ld_sel      (ld_sel),
    .busy        (busy),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .acc_req     (acc_req),
    .acc_done    (acc_done),
    .fault       (fault),
    .fault_cause (fault_cause)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [31:0] GDT_B = 32'h0010_0000;
    localparam logic [31:0] LDT_B = 32'h0002_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        real_mode = 1'b0;
    logic [1:0]  cpl = 2'd3;
    logic [31:0] gdt_base = GDT_B;
    logic [15:0] gdt_limit = 16'h00FF;
    logic [31:0] ldt_base = LDT_B;
    logic        ld_req = 1'b0;
    logic [15:0] ld_sel = '0;
    logic        busy, mem_rd, acc_done, acc_ok, fault;
    logic [31:0] mem_addr, lin_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] acc_off = '0;
    logic [2:0]  fault_cause;

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .real_mode(real_mode), .cpl(cpl),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit), .ldt_base(ldt_base),
        .ld_req(ld_req), .ld_sel(ld_sel), .busy(busy), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .acc_req(acc_req), .acc_kind(acc_kind), .acc_off(acc_off),
        .acc_done(acc_done), .acc_ok(acc_ok), .lin_addr(lin_addr),
        .fault(fault), .fault_cause(fault_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    int    stall = 0;
    int    wcnt = 0;
    string phase = "R1";
    logic [31:0] mem [logic [31:0]];

    // reference model state
    int          m_st = 0;
    logic [31:0] m_addr = '0, m_lo = '0;
    int          m_rpl = 0;
    bit          s_valid = 0, s_g = 0, s_usr = 0, s_code = 0;
    logic [31:0] s_base = '0;
    logic [19:0] s_lim = '0;
    int          s_dpl = 0, s_rpl = 0;
    bit          e_busy = 0, e_rd = 0, e_fault = 0, e_done = 0, e_ok = 0;
    logic [31:0] e_addr = '0, e_lin = '0;
    int          e_cause = 0;

    function automatic int ref_cause(int kind, logic [31:0] off, bit rm, int lvl);
        longint lim;
        int     need;
        if (!s_valid) return 6;
        if (!rm) begin
            if (!s_usr) return 2;
            if (s_code && kind == 1) return 2;
            if (!s_code && kind == 2) return 2;
            need = (lvl > s_rpl) ? lvl : s_rpl;
            if (!s_code && s_dpl < need) return 3;
        end
        lim = s_g ? (longint'(s_lim) * 4096 + 4095) : longint'(s_lim);
        if (longint'(off) > lim) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        int ac;
        bit lf;
        int lc;
        logic [63:0] dsc;
        logic [7:0]  ab;
        if (!rst_n) begin
            m_st = 0; s_valid = 0; e_busy = 0; e_rd = 0; e_fault = 0;
            e_done = 0; e_ok = 0; e_cause = 0;
        end else begin
            ac = 0; lf = 0; lc = 0;
            if (acc_req) begin
                ac    = ref_cause(int'(acc_kind), acc_off, real_mode, int'(cpl));
                e_lin = s_base + acc_off;
            end
            e_done = acc_req;
            e_ok   = acc_req && ac == 0;
            if (m_st == 0 && ld_req) begin
                m_rpl = int'(ld_sel[1:0]);
                if (real_mode) begin
                    s_valid = 1; s_base = {12'h0, ld_sel, 4'h0}; s_lim = 20'h0FFFF;
                    s_g = 0; s_usr = 1; s_code = 0; s_dpl = 0; s_rpl = m_rpl;
                end else begin
                    s_valid = 0;
                    if (!ld_sel[2] && (int'(ld_sel) | 7) > int'(gdt_limit)) begin
                        lf = 1; lc = 5;
                    end else begin
                        m_st   = 1;
                        m_addr = (ld_sel[2] ? ldt_base : gdt_base) + (32'(ld_sel) & 32'hFFF8);
                    end
                end
            end else if (m_st == 1 && mem_ack) begin
                m_lo = mem_rdata;
                m_st = 2;
            end else if (m_st == 2 && mem_ack) begin
                dsc    = {mem_rdata, m_lo};
                ab     = dsc[47:40];
                s_base = {dsc[63:56], dsc[39:16]};
                s_lim  = {dsc[51:48], dsc[15:0]};
                s_g    = dsc[55];
                s_usr  = ab[4];
                s_code = ab[3];
                s_dpl  = int'(ab[6:5]);
                s_rpl  = m_rpl;
                s_valid = ab[7];
                if (!ab[7]) begin lf = 1; lc = 4; end
                m_st = 0;
            end
            e_busy  = (m_st != 0);
            e_rd    = (m_st != 0);
            e_addr  = (m_st == 2) ? m_addr + 32'd4 : m_addr;
            e_fault = lf || (acc_req && ac != 0);
            e_cause = lf ? lc : (acc_req ? ac : 0);
        end
    end

    task automatic chk(string nm, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", phase, nm, act, exp);
        end
    endtask

    // compare against model and serve memory, both on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("busy",     32'(busy),        32'(e_busy));
            chk("mem_rd",   32'(mem_rd),      32'(e_rd));
            if (e_rd) chk("mem_addr", mem_addr, e_addr);
            chk("acc_done", 32'(acc_done),    32'(e_done));
            chk("acc_ok",   32'(acc_ok),      32'(e_ok));
            if (e_done) chk("lin_addr", lin_addr, e_lin);
            chk("fault",    32'(fault),       32'(e_fault));
            chk("cause",    32'(fault_cause), 32'(e_cause));
        end
        if (mem_rd) begin
            if (wcnt >= stall) begin
                mem_ack   = 1'b1;
                mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                wcnt      = 0;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt    = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic put_desc(logic [31:0] tb, int idx, logic [31:0] base,
                            logic [19:0] lim, bit g, logic [7:0] acc);
        logic [31:0] a;
        a = tb + 32'(idx * 8);
        mem[a]       = {base[15:0], lim[15:0]};
        mem[a + 32'd4] = {base[31:24], g, 3'b000, lim[19:16], acc, base[23:16]};
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic do_load(logic [15:0] s);
        ld_req = 1'b1; ld_sel = s;
        step();
        ld_req = 1'b0;
        while (busy) step();
        step();
    endtask

    task automatic do_acc(int k, logic [31:0] off);
        acc_req = 1'b1; acc_kind = 2'(k); acc_off = off;
        step();
        acc_req = 1'b0;
        step();
    endtask

    initial begin
        put_desc(GDT_B, 1, 32'h0004_0800, 20'h0FFFF, 1'b0, 8'hF2);
        put_desc(GDT_B, 2, 32'h0000_1000, 20'h00FFF, 1'b0, 8'h92);
        put_desc(GDT_B, 3, 32'h0004_0800, 20'h0FFFF, 1'b0, 8'hF8);
        put_desc(GDT_B, 4, 32'h0000_0000, 20'h0FFFF, 1'b0, 8'h82);
        put_desc(GDT_B, 5, 32'h0000_2000, 20'h0FFFF, 1'b0, 8'h72);
        put_desc(LDT_B, 7, 32'h0118_0800, 20'h1FFFF, 1'b1, 8'hF2);

        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        step(); step();                                   // R1 reset state compared

        phase = "R10"; do_acc(0, 32'h0);                  // no segment yet -> 6
        phase = "R1";  stall = 0; do_load(16'h0008);
        phase = "R9";  do_acc(0, 32'h10); do_acc(1, 32'hFFFF);
        phase = "R5";  do_acc(0, 32'h0001_0000);
        phase = "R6";  do_acc(2, 32'h0);
        phase = "R1";  stall = 2; do_load(16'h001B);
        phase = "R9";  do_acc(2, 32'h10);
        phase = "R6";  do_acc(1, 32'h10);
        phase = "R7";  stall = 1; do_load(16'h0010);
        cpl = 2'd0; do_acc(0, 32'h10);
        cpl = 2'd3; do_acc(0, 32'h10);
        phase = "R10"; do_acc(1, 32'h2000);               // privilege beats limit
        cpl = 2'd0; do_acc(0, 32'h2000);
        phase = "R7";  do_load(16'h0013); do_acc(0, 32'h0);  // RPL raises the level
        phase = "R6";  do_load(16'h0020); do_acc(0, 32'h0); do_acc(2, 32'h0);
        phase = "R4";  do_load(16'h0028); do_acc(0, 32'h0);
        phase = "R2";  do_load(16'h0140); do_acc(0, 32'h0);
        do_load(16'h0100);
        phase = "R4";  do_load(16'h00F8);                 // last entry inside limit, empty
        phase = "R3";  cpl = 2'd3; stall = 0; do_load(16'h003F);
        do_acc(0, 32'h0008_8010);
        phase = "R5";  do_acc(1, 32'h1FFF_FFFF); do_acc(0, 32'h2000_0000);
        phase = "R8";  real_mode = 1'b1; do_load(16'h1234);
        do_acc(2, 32'hFFFF); do_acc(1, 32'h0001_0000);
        real_mode = 1'b0;
        phase = "R11"; stall = 3;
        ld_req = 1'b1; ld_sel = 16'h0008; step();
        ld_sel = 16'h0020; acc_req = 1'b1; acc_kind = 2'd0; acc_off = 32'h4; step();
        ld_req = 1'b0; acc_req = 1'b0;
        while (busy) step();
        step();
        do_acc(1, 32'h10);                                // data segment kept, not system
        step(); step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule